// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block picks the next fetch address for a 32-bit RISC core whose control transfers have one delay slot. On each cycle the core presents the address of the instruction it has just fetched, the instruction word, and the two source operand values. The unit decodes the instruction. It evaluates equal and not-equal branches, region jumps, calls that save a return address, and jumps through a register. It then returns the address to fetch next.

A taken transfer does not redirect fetch at once. The unit first returns the sequential address so that the delay-slot instruction is fetched. It keeps the destination in a single pending register and releases it as the next address on the following valid cycle. Calls also produce a register-file write of the return address, which skips the delay slot. Two faults are reported, and each one suppresses the transfer: a register jump to an address that is not word aligned, and a transfer placed in a delay slot. When `valid_i` is low, the core is stalled and the pending state is held.

Top module: `npc_unit`

## Requirements
- R1: After reset deasserts, no redirect is pending. A redirect that was pending when reset asserted is discarded, and `next_pc_o` equals `pc_i + 4`.
- R2: An instruction that is not a control transfer gives `next_pc_o = pc_i + 4` with all flags low. Control transfers are: opcode (bits 31:26) 0x04, 0x05, 0x02 or 0x03, and opcode 0x00 with function field (bits 5:0) 0x08.
- R3: Opcode 0x04 is taken when `rs_val_i == rt_val_i`. Its destination is `pc_i + 4 + (sign-extended bits 15:0 << 2)`.
- R4: Opcode 0x05 is taken when `rs_val_i != rt_val_i`, and uses the same destination formula as R3.
- R5: Opcode 0x02 is always taken. Its destination is bits 31:28 of `pc_i + 4` joined to bits 25:0 of the instruction followed by two zero bits.
- R6: Opcode 0x03 has the same destination as R5. It also raises `link_we_o` with `link_idx_o = 31` and `link_val_o = pc_i + 8`.
- R7: Opcode 0x00 with function 0x08 jumps to `rs_val_i`.
- R8: On a taken transfer, `taken_o` is high and `next_pc_o = pc_i + 4`. On the next valid cycle, `next_pc_o` equals the destination.
- R9: A register jump whose destination has bits 1:0 nonzero raises `addr_err_o`. It is not taken, and no redirect follows.
- R10: A control transfer in a delay slot raises `slot_err_o`. It is not taken and writes no link. `next_pc_o` is the pending destination, and no further redirect follows.
- R11: While `valid_i` is low, all flags are low, pending state is kept, and `next_pc_o` shows the pending destination if one exists, otherwise `pc_i + 4`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Instruction presented this cycle |
| pc_i | input | 32 | Address of the presented instruction |
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | 32 | First source operand value |
| rt_val_i | input | 32 | Second source operand value |
| next_pc_o | output | 32 | Address to fetch next |
| taken_o | output | 1 | A transfer was accepted this cycle |
| link_we_o | output | 1 | Write the return address |
| link_idx_o | output | 5 | Return register index |
| link_val_o | output | 32 | Return address value |
| addr_err_o | output | 1 | Misaligned register jump, suppressed |
| slot_err_o | output | 1 | Transfer in delay slot, suppressed |

## Verification
The assertions assume that `pc_i` on each valid cycle is the address the unit returned on the previous valid cycle. They also assume that inputs settle before the sampling edge. The scoreboard driver keeps its own fetch address and feeds it back as `pc_i`. It moves that address explicitly only to place a jump just below a 256 MiB region boundary. Stall cycles, resets while a redirect is pending, and transfers in delay slots are inserted at chosen points in the instruction stream.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam logic [5:0] OP_SPECIAL = 6'h00;
  localparam logic [5:0] OP_J       = 6'h02;
  localparam logic [5:0] OP_JAL     = 6'h03;
  localparam logic [5:0] OP_BEQ     = 6'h04;
  localparam logic [5:0] OP_BNE     = 6'h05;
  localparam logic [5:0] FN_JR      = 6'h08;

  localparam int unsigned IMM_W  = 16;
  localparam int unsigned IDX_W  = 26;
  localparam int unsigned REGION = 28;

  typedef enum logic [2:0] {
    XF_NONE,
    XF_BEQ,
    XF_BNE,
    XF_J,
    XF_JAL,
    XF_JR
  } xfer_e;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [31:0]      instr_i,
  output xfer_e            kind_o,
  output logic [IMM_W-1:0] imm_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [5:0] opc, fn;

  assign opc   = instr_i[31:26];
  assign fn    = instr_i[5:0];
  assign imm_o = instr_i[IMM_W-1:0];
  assign idx_o = instr_i[IDX_W-1:0];

  always_comb begin
    unique case (opc)
      OP_BEQ:     kind_o = XF_BEQ;
      OP_BNE:     kind_o = XF_BNE;
      OP_J:       kind_o = XF_J;
      OP_JAL:     kind_o = XF_JAL;
      OP_SPECIAL: kind_o = (fn == FN_JR) ? XF_JR : XF_NONE;
      default:    kind_o = XF_NONE;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  xfer_e            kind_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  rs_i,
  input  logic [XLEN-1:0]  rt_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [XLEN-1:0]  seq_o,
  output logic [XLEN-1:0]  dest_o,
  output logic             cond_o,
  output logic             misalign_o,
  output logic [XLEN-1:0]  link_o
);
  localparam int unsigned SEXT_W = XLEN - IMM_W - 2;

  logic [XLEN-1:0] br_off, br_dest, rg_dest;
  logic            ops_eq;

  assign seq_o   = pc_i + XLEN'(4);
  assign link_o  = pc_i + XLEN'(8);
  assign br_off  = {{SEXT_W{imm_i[IMM_W-1]}}, imm_i, 2'b00};
  assign br_dest = seq_o + br_off;
  assign rg_dest = {seq_o[XLEN-1:REGION], idx_i, 2'b00};
  assign ops_eq  = (rs_i == rt_i);

  always_comb begin
    dest_o     = seq_o;
    cond_o     = 1'b0;
    misalign_o = 1'b0;
    unique case (kind_i)
      XF_BEQ: begin dest_o = br_dest; cond_o = ops_eq;  end
      XF_BNE: begin dest_o = br_dest; cond_o = !ops_eq; end
      XF_J, XF_JAL: begin dest_o = rg_dest; cond_o = 1'b1; end
      XF_JR: begin
        dest_o     = rs_i;
        cond_o     = 1'b1;
        misalign_o = |rs_i[1:0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/npc_slot.sv
module npc_slot #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic            take_i,
  input  logic [XLEN-1:0] dest_i,
  output logic            pend_o,
  output logic [XLEN-1:0] dest_o
);
  logic            pend_q;
  logic [XLEN-1:0] dest_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      dest_q <= '0;
    end else if (valid_i) begin
      pend_q <= take_i;
      if (take_i) dest_q <= dest_i;
    end
  end

  assign pend_o = pend_q;
  assign dest_o = dest_q;

  // R8
  arm_after_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && take_i |=> pend_q && dest_q == $past(dest_i));

  // R8
  release_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && pend_q |=> !pend_q);

  // R11
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(pend_q) && $stable(dest_q));
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter logic [4:0]  LINK_REG = 5'd31
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] rs_val_i,
  input  logic [XLEN-1:0] rt_val_i,
  output logic [XLEN-1:0] next_pc_o,
  output logic            taken_o,
  output logic            link_we_o,
  output logic [4:0]      link_idx_o,
  output logic [XLEN-1:0] link_val_o,
  output logic            addr_err_o,
  output logic            slot_err_o
);
  xfer_e            kind;
  logic [IMM_W-1:0] imm;
  logic [IDX_W-1:0] idx;
  logic [XLEN-1:0]  seq, dest, pend_dest;
  logic             cond, misalign, pend, is_xfer, bad_jr;

  npc_decode i_decode (
    .instr_i (instr_i),
    .kind_o  (kind),
    .imm_o   (imm),
    .idx_o   (idx)
  );

  npc_target #(.XLEN(XLEN)) i_target (
    .kind_i     (kind),
    .pc_i       (pc_i),
    .rs_i       (rs_val_i),
    .rt_i       (rt_val_i),
    .imm_i      (imm),
    .idx_i      (idx),
    .seq_o      (seq),
    .dest_o     (dest),
    .cond_o     (cond),
    .misalign_o (misalign),
    .link_o     (link_val_o)
  );

  assign is_xfer = (kind != XF_NONE);
  assign bad_jr  = (kind == XF_JR) && misalign;

  // a delay-slot instruction never starts a transfer of its own
  assign taken_o    = valid_i && !pend && cond && !bad_jr;
  assign addr_err_o = valid_i && !pend && bad_jr;
  assign slot_err_o = valid_i && pend && is_xfer;
  assign link_we_o  = taken_o && (kind == XF_JAL);
  assign link_idx_o = LINK_REG;
  assign next_pc_o  = pend ? pend_dest : seq;

  npc_slot #(.XLEN(XLEN)) i_slot (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .take_i  (taken_o),
    .dest_i  (dest),
    .pend_o  (pend),
    .dest_o  (pend_dest)
  );

  // R9 R10
  flags_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({taken_o, addr_err_o, slot_err_o}));

  // R6
  link_call_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> taken_o && link_idx_o == 5'd31 && link_val_o == seq + XLEN'(4));

  // R2
  seq_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !pend && !is_xfer |-> next_pc_o == pc_i + XLEN'(4) && !taken_o);

  // R8
  slot_redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && taken_o |=> next_pc_o == $past(dest));

  // R11
  stall_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !taken_o && !link_we_o && !addr_err_o && !slot_err_o);
endmodule

// File: tb/test_npc_unit.sv
`timescale 1ns/1ps
module test_npc_unit;
  typedef struct {
    string       tag;
    logic [31:0] npc;
    logic        tk;
    logic        lwe;
    logic [31:0] lval;
    logic        aerr;
    logic        serr;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] pc = '0, instr = '0, rs_v = '0, rt_v = '0;
  logic [31:0] next_pc, link_val;
  logic        taken, link_we, addr_err, slot_err;
  logic [4:0]  link_idx;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  exp_t sb_q[$];

  logic [31:0] pc_m = 32'h0040_0000;
  logic        pend_m = 1'b0;
  logic [31:0] tgt_m = '0;

  always #2 clk = ~clk;

  npc_unit i_npc_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .pc_i(pc), .instr_i(instr),
    .rs_val_i(rs_v), .rt_val_i(rt_v), .next_pc_o(next_pc), .taken_o(taken),
    .link_we_o(link_we), .link_idx_o(link_idx), .link_val_o(link_val),
    .addr_err_o(addr_err), .slot_err_o(slot_err)
  );

  function automatic logic [31:0] f_beq(input logic [15:0] o); return {6'h04, 10'd0, o}; endfunction
  function automatic logic [31:0] f_bne(input logic [15:0] o); return {6'h05, 10'd0, o}; endfunction
  function automatic logic [31:0] f_j(input logic [25:0] x);   return {6'h02, x}; endfunction
  function automatic logic [31:0] f_jal(input logic [25:0] x); return {6'h03, x}; endfunction
  localparam logic [31:0] I_JR   = 32'h03E0_0008;
  localparam logic [31:0] I_ADD  = 32'h012A_4020;
  localparam logic [31:0] I_ADDI = 32'h2129_0005;

  task automatic issue(input string tag, input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
    exp_t e;
    logic [5:0]  op;
    logic        xf, cnd;
    logic [31:0] dst, seq;
    @(posedge clk); #1;
    valid = 1'b1; pc = pc_m; instr = ins; rs_v = a; rt_v = b;
    op  = ins[31:26];
    xf  = (op == 6'h04) || (op == 6'h05) || (op == 6'h02) || (op == 6'h03) ||
          (op == 6'h00 && ins[5:0] == 6'h08);
    seq = pc_m + 32'd4;
    e = '{tag: tag, npc: seq, tk: 1'b0, lwe: 1'b0, lval: pc_m + 32'd8, aerr: 1'b0, serr: 1'b0};
    if (pend_m) begin
      e.npc = tgt_m; e.serr = xf; pend_m = 1'b0;
    end else begin
      cnd = 1'b0; dst = seq;
      case (op)
        6'h04: begin cnd = (a == b); dst = seq + {{14{ins[15]}}, ins[15:0], 2'b00}; end
        6'h05: begin cnd = (a != b); dst = seq + {{14{ins[15]}}, ins[15:0], 2'b00}; end
        6'h02, 6'h03: begin cnd = 1'b1; dst = {seq[31:28], ins[25:0], 2'b00}; end
        6'h00: if (ins[5:0] == 6'h08) begin
          dst = a;
          if (a[1:0] != 2'b00) e.aerr = 1'b1; else cnd = 1'b1;
        end
        default: ;
      endcase
      e.tk  = cnd;
      e.lwe = cnd && (op == 6'h03);
      if (cnd) begin pend_m = 1'b1; tgt_m = dst; end
    end
    sb_q.push_back(e);
    pc_m = e.npc;
  endtask

  task automatic idle(input string tag);
    exp_t e;
    @(posedge clk); #1;
    valid = 1'b0; pc = pc_m; instr = I_JR; rs_v = 32'h0000_0800;
    e = '{tag: tag, npc: pend_m ? tgt_m : pc_m + 32'd4, tk: 1'b0, lwe: 1'b0,
          lval: '0, aerr: 1'b0, serr: 1'b0};
    sb_q.push_back(e);
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    valid = 1'b0; rst_n = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    pend_m = 1'b0;
  endtask

  // monitor: compares at the falling edge, away from the sampling edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_run++;
        if (next_pc !== e.npc || taken !== e.tk || link_we !== e.lwe ||
            addr_err !== e.aerr || slot_err !== e.serr ||
            (e.lwe && (link_val !== e.lval || link_idx !== 5'd31))) begin
          n_fail++;
          $display("FAIL %s: npc=%h tk=%b lwe=%b lidx=%0d lval=%h aerr=%b serr=%b | exp npc=%h tk=%b lwe=%b lidx=31 lval=%h aerr=%b serr=%b",
                   e.tag, next_pc, taken, link_we, link_idx, link_val, addr_err, slot_err,
                   e.npc, e.tk, e.lwe, e.lval, e.aerr, e.serr);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: run did not finish, exp completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle("R1");                                  // R1 reset state, R11 stall
    issue("R2", I_ADD, 32'd1, 32'd2);            // R2
    issue("R2", I_ADDI, 32'd1, 32'd2);           // R2
    issue("R3", f_beq(16'h0010), 32'h55, 32'h55);// R3 taken
    issue("R8", I_ADD, 0, 0);                    // R8 slot -> target
    issue("R3", f_beq(16'h0010), 32'h55, 32'h56);// R3 not taken
    issue("R4", f_bne(16'hFFF0), 32'h1, 32'h2);  // R4 backward
    issue("R8", I_ADDI, 0, 0);                   // R8
    issue("R4", f_bne(16'h0004), 32'h7, 32'h7);  // R4 not taken
    issue("R2", I_ADD, 0, 0);                    // R2 no stale redirect
    pc_m = 32'h2FFF_FFFC;
    issue("R5", f_j(26'h000_0123), 0, 0);        // R5 region from pc+4
    issue("R8", I_ADD, 0, 0);                    // R8
    issue("R6", f_jal(26'h3FF_FFFF), 0, 0);      // R6 link
    issue("R8", I_ADD, 0, 0);                    // R8
    issue("R7", I_JR, 32'h0001_2340, 0);         // R7
    issue("R8", I_ADD, 0, 0);                    // R8
    issue("R9", I_JR, 32'h0001_2342, 0);         // R9 misaligned
    issue("R9", I_ADD, 0, 0);                    // R9 no redirect
    issue("R9", I_JR, 32'h0001_2341, 0);         // R9
    issue("R5", f_j(26'h000_0400), 0, 0);        // R5
    issue("R10", f_beq(16'h0020), 32'h3, 32'h3); // R10 branch in slot
    issue("R10", I_ADD, 0, 0);                   // R10 no second redirect
    issue("R3", f_beq(16'h0008), 32'h9, 32'h9);  // R3
    issue("R10", f_jal(26'h000_0777), 0, 0);     // R10 call in slot, no link
    issue("R10", I_ADD, 0, 0);                   // R10
    issue("R4", f_bne(16'h0002), 32'h1, 32'h0);  // R4
    idle("R11");                                 // R11 stall keeps redirect
    idle("R11");                                 // R11
    issue("R11", I_ADD, 0, 0);                   // R11 redirect after stall
    issue("R7", I_JR, 32'h00AB_CD00, 0);         // R7
    do_reset();
    idle("R1");                                  // R1 pending dropped
    issue("R1", I_ADD, 0, 0);                    // R1
    @(negedge clk); @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule